// File: doc/BRIEF.md
# CPU Debug Control Port

This block is a two-word bus slave through which an external host controls a small soft CPU and inspects its registers. On the host side it sees a single-cycle bus with an address, a write enable, write data and combinational read data. On the core side it drives a halt level, a register index, and one-clock pulses for reset, single step, interrupt request and cache clear. In return it takes a halted indication, the value of the selected core register, and a bank of peripheral register values.

The host uses one control word to command the core and choose a register, and one data word to read that register back. A register read goes like this. The host writes the halt bit together with a 6-bit index. It then polls the control word until the ready bit is set, and then reads the data word. Indices 0 to 31 come from the core: 0 to 15 are the supervisor set and 16 to 31 the user set. In each set the last three entries are stack pointer, condition codes and program counter. Indices 32 and up come from peripheral registers. A single step advances the core by one instruction. Ready is withheld until the core has left the halted state and come back to it.

Top module: `cpu_dbg_port`

## Requirements
- R1: The control word decodes at address 0x60 and the data word at 0x61. A write to any other address changes nothing, and a read of any other address returns zero.
- R2: A control write loads the halt level from bit 10 and the register index from bits 5:0. Both hold until the next control write. Reading the control word returns the index in bits 5:0, ready in bit 9 and the halt level in bit 10, with every other bit zero.
- R3: Bit 6 of a control write produces a reset pulse exactly one clock long, high in the cycle after the write. When written as reset plus halt, the halt level stays asserted.
- R4: Bit 7 produces a one-clock interrupt pulse and bit 11 a one-clock cache-clear pulse, each in the cycle after the write.
- R5: A control write with bit 8 (step) set and halt clear produces a one-clock step pulse and keeps the halt level asserted. A write with both step and halt set produces no step pulse.
- R6: After a step write, ready reads 0 until the core has dropped its halted indication and raised it again. Exactly one step pulse is issued per step write.
- R7: A control write of all zeros releases the core: the halt level drops and ready reads 0.
- R8: Indices 0 to 31 return the core register value. Every control write clears ready for at least SETTLE cycles (2 by default), so that a newly chosen value has time to arrive.
- R9: Indices 32 to 39 and 44 to 47 return peripheral slots 0 to 7 and 12 to 15. Indices 40 to 43 and 48 to 63 return zero.
- R10: Ready is set only while halt is requested, the core reports halted, no step is outstanding and the settle time has passed. Once ready is set, the data word holds the value for the selected index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write enable |
| bus_addr | input | 8 | Bus word address |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data (combinational on address) |
| core_halt | output | 1 | Halt request level to the core |
| core_reset | output | 1 | Core reset pulse |
| core_step | output | 1 | Single-step pulse |
| core_irq | output | 1 | Interrupt request pulse |
| core_cache_clr | output | 1 | Cache-clear pulse |
| core_reg_idx | output | 6 | Selected register index |
| core_halted | input | 1 | Core reports it is halted |
| core_reg_val | input | 32 | Value of the selected core register |
| periph_vals | input | 512 | Sixteen 32-bit peripheral register values, slot k at bits 32k+31:32k |

## Verification
The hardest situation to reach from the ports is the step window. Ready must stay low while the core is briefly running and must come back only after it halts again. A bench model of the core therefore drops its halted output for several cycles after each step pulse. The bench polls the control word through that window and counts every step pulse seen. The full sweep of all 64 indices includes the unmapped peripheral slots, which are driven with non-zero values so that any leak through the mask shows up.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
    localparam int DW    = 32;
    localparam int IDX_W = 6;

    // control word bit positions
    localparam int B_RST  = 6;
    localparam int B_IRQ  = 7;
    localparam int B_STEP = 8;
    localparam int B_RDY  = 9;
    localparam int B_HALT = 10;
    localparam int B_CCLR = 11;

    typedef struct packed {
        logic             halt;
        logic [IDX_W-1:0] idx;
    } ctrl_state_t;

    typedef struct packed {
        logic rst;
        logic irq;
        logic step;
        logic cclr;
    } pulse_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAVE,
        ST_RETURN
    } step_st_t;

    function automatic pulse_t decode_pulses(input logic [DW-1:0] w);
        pulse_t p;
        p.rst  = w[B_RST];
        p.irq  = w[B_IRQ];
        p.step = w[B_STEP] & ~w[B_HALT];
        p.cclr = w[B_CCLR];
        return p;
    endfunction

    function automatic logic [DW-1:0] pack_status(input ctrl_state_t c, input logic rdy);
        logic [DW-1:0] w;
        w             = '0;
        w[IDX_W-1:0]  = c.idx;
        w[B_RDY]      = rdy;
        w[B_HALT]     = c.halt;
        return w;
    endfunction
endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
    import dbg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_ctrl,
    input  logic [DW-1:0] wdata,
    output ctrl_state_t   ctrl_q,
    output pulse_t        pulse_q
);
    pulse_t req;
    assign req = decode_pulses(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            pulse_q <= '0;
        end else begin
            pulse_q <= wr_ctrl ? req : '0;
            if (wr_ctrl) begin
                // a step keeps the core parked once its instruction retires
                ctrl_q.halt <= wdata[B_HALT] | req.step;
                ctrl_q.idx  <= wdata[IDX_W-1:0];
            end
        end
    end

    p_step_from_write_r5: assert property (@(posedge clk) disable iff (rst)
        pulse_q.step |-> $past(wr_ctrl && wdata[B_STEP] && !wdata[B_HALT]));

    p_reset_one_clock_r3: assert property (@(posedge clk) disable iff (rst)
        (pulse_q.rst && !$past(wr_ctrl)) |-> 1'b0);

    p_halt_holds_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_ctrl |=> $stable(ctrl_q));
endmodule

// File: rtl/dbg_step_seq.sv
module dbg_step_seq
    import dbg_pkg::*;
#(
    parameter int SETTLE = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_ctrl,
    input  logic step_req,
    input  logic halt_lvl,
    input  logic core_halted,
    output logic ready
);
    localparam int CNT_W = (SETTLE < 1) ? 1 : $clog2(SETTLE + 1);

    step_st_t         st_q;
    logic [CNT_W-1:0] settle_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            settle_q <= '0;
        end else begin
            if (wr_ctrl)
                settle_q <= CNT_W'(SETTLE);
            else if (settle_q != '0)
                settle_q <= settle_q - 1'b1;

            unique case (st_q)
                ST_IDLE:   if (wr_ctrl && step_req) st_q <= ST_LEAVE;
                ST_LEAVE:  if (!core_halted)        st_q <= ST_RETURN;
                ST_RETURN: if (core_halted)         st_q <= ST_IDLE;
                default:                            st_q <= ST_IDLE;
            endcase
        end
    end

    assign ready = (st_q == ST_IDLE) && (settle_q == '0) && core_halted && halt_lvl;

    p_ready_drops_after_write_r8: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> !ready);

    p_no_ready_before_return_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_LEAVE) |-> !ready);

    p_ready_needs_halt_r10: assert property (@(posedge clk) disable iff (rst)
        ready |-> (core_halted && halt_lvl));
endmodule

// File: rtl/dbg_readback.sv
module dbg_readback
    import dbg_pkg::*;
#(
    parameter int          NPER       = 16,
    parameter logic [15:0] PERIPH_MAP = 16'hF0FF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [IDX_W-1:0]   idx,
    input  logic [DW-1:0]      core_reg_val,
    input  logic [NPER*DW-1:0] periph_vals,
    output logic [DW-1:0]      data
);
    localparam int SLOT_W = (NPER < 2) ? 1 : $clog2(NPER);
    localparam int HALF   = 2 ** (IDX_W - 1);

    logic [DW-1:0] slot [NPER];

    for (genvar g = 0; g < NPER; g++) begin : g_slot
        if (g < 16 && PERIPH_MAP[g]) begin : g_on
            assign slot[g] = periph_vals[g*DW +: DW];
        end else begin : g_off
            assign slot[g] = '0;
        end
    end

    logic [IDX_W-2:0] off;
    assign off = idx[IDX_W-2:0];

    always_comb begin
        data = '0;
        if (!idx[IDX_W-1])
            data = core_reg_val;
        else if (int'(off) < NPER)
            data = slot[off[SLOT_W-1:0]];
    end

    p_high_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (idx[IDX_W-1] && int'(off) >= 16) |-> (data == '0));

    p_core_range_passthru_r8: assert property (@(posedge clk) disable iff (rst)
        (int'(idx) < HALF) |-> (data == core_reg_val));
endmodule

// File: rtl/cpu_dbg_port.sv
module cpu_dbg_port
    import dbg_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter logic [7:0]  CTRL_ADDR  = 8'h60,
    parameter logic [7:0]  DATA_ADDR  = 8'h61,
    parameter int          SETTLE     = 2,
    parameter int          NPER       = 16,
    parameter logic [15:0] PERIPH_MAP = 16'hF0FF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               core_halt,
    output logic               core_reset,
    output logic               core_step,
    output logic               core_irq,
    output logic               core_cache_clr,
    output logic [5:0]         core_reg_idx,
    input  logic               core_halted,
    input  logic [31:0]        core_reg_val,
    input  logic [NPER*32-1:0] periph_vals
);
    logic sel_ctrl, sel_data, wr_ctrl, ready;
    ctrl_state_t ctrl_q;
    pulse_t      pulse_q, req;
    logic [DW-1:0] data;

    assign sel_ctrl = (bus_addr == ADDR_W'(CTRL_ADDR));
    assign sel_data = (bus_addr == ADDR_W'(DATA_ADDR));
    assign wr_ctrl  = bus_we && sel_ctrl;
    assign req      = decode_pulses(bus_wdata);

    dbg_cmd_decode u_dec (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (wr_ctrl),
        .wdata   (bus_wdata),
        .ctrl_q  (ctrl_q),
        .pulse_q (pulse_q)
    );

    dbg_step_seq #(.SETTLE(SETTLE)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .wr_ctrl     (wr_ctrl),
        .step_req    (req.step),
        .halt_lvl    (ctrl_q.halt),
        .core_halted (core_halted),
        .ready       (ready)
    );

    dbg_readback #(.NPER(NPER), .PERIPH_MAP(PERIPH_MAP)) u_rb (
        .clk          (clk),
        .rst          (rst),
        .idx          (ctrl_q.idx),
        .core_reg_val (core_reg_val),
        .periph_vals  (periph_vals),
        .data         (data)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl)      bus_rdata = pack_status(ctrl_q, ready);
        else if (sel_data) bus_rdata = data;
    end

    assign core_halt      = ctrl_q.halt;
    assign core_reg_idx   = ctrl_q.idx;
    assign core_reset     = pulse_q.rst;
    assign core_step      = pulse_q.step;
    assign core_irq       = pulse_q.irq;
    assign core_cache_clr = pulse_q.cclr;

    p_foreign_read_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (!sel_ctrl && !sel_data) |-> (bus_rdata == '0));

    p_foreign_write_ignored_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !sel_ctrl) |=> ($stable(core_halt) && $stable(core_reg_idx) && !core_step));

    p_release_clears_ready_r7: assert property (@(posedge clk) disable iff (rst)
        !core_halt |-> !bus_rdata[B_RDY] || !sel_ctrl);
endmodule

// File: tb/test_cpu_dbg_port.sv
module test_cpu_dbg_port;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_CTRL = 8'h60;
    localparam logic [7:0] A_DATA = 8'h61;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_we = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic core_halt, core_reset, core_step, core_irq, core_cache_clr;
    logic [5:0] core_reg_idx;
    logic core_halted;
    logic [31:0] core_reg_val;
    logic [16*32-1:0] periph_vals;

    int n_checks = 0;
    int n_fail = 0;
    int step_pulses = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_dbg_port i_cpu_dbg_port (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_halt(core_halt),
        .core_reset(core_reset), .core_step(core_step), .core_irq(core_irq),
        .core_cache_clr(core_cache_clr), .core_reg_idx(core_reg_idx),
        .core_halted(core_halted), .core_reg_val(core_reg_val),
        .periph_vals(periph_vals)
    );

    function automatic logic [31:0] core_fn(input int i);
        return {8'hC0 ^ 8'(i), 8'(i * 3), 16'h1234 + 16'(i)};
    endfunction

    function automatic logic [31:0] per_fn(input int k);
        return 32'hE000_0000 | (32'(k) * 32'h111);
    endfunction

    function automatic logic [31:0] exp_data(input int i);
        if (i < 32) return core_fn(i);
        if (i < 40 || (i >= 44 && i < 48)) return per_fn(i - 32);
        return 32'h0;
    endfunction

    always_comb
        for (int k = 0; k < 16; k++) periph_vals[k*32 +: 32] = per_fn(k);

    // core model: one-cycle register readback, three running cycles per step
    logic halt_d;
    logic [2:0] run_cnt;
    always_ff @(posedge clk) begin
        if (rst) begin
            halt_d <= 1'b0;
            run_cnt <= '0;
            core_reg_val <= '0;
        end else begin
            halt_d <= core_halt;
            if (core_step) run_cnt <= 3'd3;
            else if (run_cnt != 0) run_cnt <= run_cnt - 3'd1;
            core_reg_val <= core_fn(int'(core_reg_idx));
        end
    end
    assign core_halted = halt_d && (run_cnt == 0);

    always @(posedge clk) if (!rst && core_step) step_pulses++;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // drive a write on a falling edge; returns at the next falling edge
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
        #1;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_ready(output logic got);
        logic [31:0] w;
        got = 1'b0;
        for (int t = 0; t < 20 && !got; t++) begin
            bus_read(A_CTRL, w);
            if (w[9]) got = 1'b1;
            else @(negedge clk);
        end
    endtask

    initial begin
        logic [31:0] w;
        logic got;
        int sp0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        bus_read(A_CTRL, w);
        check(w, 32'h0, "R2 ctrl after reset");
        check({31'b0, core_halt}, 32'h0, "R2 halt after reset");
        check({28'b0, core_reset, core_step, core_irq, core_cache_clr}, 32'h0, "R3 R4 pulses idle after reset");

        // sweep every index
        for (int i = 0; i < 64; i++) begin
            bus_write(A_CTRL, 32'h400 | 32'(i));
            bus_read(A_CTRL, w);
            check(w, 32'h400 | 32'(i), "R8 ready low, index and halt after write");
            wait_ready(got);
            check({31'b0, got}, 32'h1, "R10 ready reached");
            bus_read(A_DATA, w);
            check(w, exp_data(i), (i < 32) ? "R8 core register readback" : "R9 peripheral readback");
        end

        // foreign addresses: index is 63, halted and ready
        bus_write(8'h62, 32'h0000_0105);
        bus_write(8'h5F, 32'h0000_0000);
        bus_read(A_CTRL, w);
        check(w, 32'h63F, "R1 foreign writes leave ctrl unchanged");
        check({31'b0, core_step}, 32'h0, "R1 foreign write gives no step");
        bus_read(8'h62, w);
        check(w, 32'h0, "R1 foreign read 0x62");
        bus_read(8'h5F, w);
        check(w, 32'h0, "R1 foreign read 0x5F");

        // reset plus halt
        bus_write(A_CTRL, 32'h440);
        check({31'b0, core_reset}, 32'h1, "R3 reset pulse high");
        check({31'b0, core_halt}, 32'h1, "R3 halt kept with reset");
        @(negedge clk);
        check({31'b0, core_reset}, 32'h0, "R3 reset pulse one clock");

        // interrupt and cache clear
        bus_write(A_CTRL, 32'h480);
        check({30'b0, core_irq, core_cache_clr}, 32'h2, "R4 irq pulse high");
        @(negedge clk);
        check({31'b0, core_irq}, 32'h0, "R4 irq one clock");
        bus_write(A_CTRL, 32'hC00);
        check({30'b0, core_irq, core_cache_clr}, 32'h1, "R4 cache clear pulse high");
        @(negedge clk);
        check({31'b0, core_cache_clr}, 32'h0, "R4 cache clear one clock");

        // single step on index 15
        wait_ready(got);
        sp0 = step_pulses;
        bus_write(A_CTRL, 32'h10F);
        check({31'b0, core_step}, 32'h1, "R5 step pulse high");
        check({31'b0, core_halt}, 32'h1, "R5 halt held through step");
        bus_read(A_CTRL, w);
        check({31'b0, w[9]}, 32'h0, "R6 ready low after step");
        @(negedge clk);
        check({31'b0, core_step}, 32'h0, "R5 step one clock");
        repeat (3) @(negedge clk);
        bus_read(A_CTRL, w);
        check({31'b0, w[9]}, 32'h0, "R6 ready low while core runs");
        wait_ready(got);
        check({31'b0, got}, 32'h1, "R6 ready after core halts again");
        check(32'(step_pulses - sp0), 32'h1, "R6 exactly one step pulse");
        bus_read(A_DATA, w);
        check(w, core_fn(15), "R10 data after step");

        // step with halt set
        sp0 = step_pulses;
        bus_write(A_CTRL, 32'h500);
        check({31'b0, core_step}, 32'h0, "R5 step with halt gives no pulse");
        repeat (4) @(negedge clk);
        check(32'(step_pulses - sp0), 32'h0, "R5 no pulse later either");

        // release
        bus_write(A_CTRL, 32'h0);
        check({31'b0, core_halt}, 32'h0, "R7 halt released");
        repeat (5) @(negedge clk);
        bus_read(A_CTRL, w);
        check(w, 32'h0, "R7 ready low while running");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule